// File: doc/BRIEF.md
# Wavefront Float Compare and Three-Way Select Unit

This block evaluates one single-precision operation over a 64-element wavefront using a 16-lane datapath. A pass starts with a start pulse. It then takes one slice of 16 elements in each of four consecutive clock cycles, so a new element-wise operation enters every lane on every clock. The block offers two kinds of operation, chosen by a 6-bit opcode that is latched at the start pulse.

- **Compare passes** test operand A against operand B with any of sixteen IEEE-style relational predicates, covering both ordered and unordered forms. The outcome of each element is one bit. The 64 bits are packed into a condition mask, which is published at the end of the pass. An opcode flag can copy the same mask into the execute-mask output.
- **Select passes** write, for every active lane, the minimum, maximum or median of operands A, B and C as a 32-bit value.

The execute mask supplied with the start pulse decides which elements take part in the pass. An inactive element gives a zero condition bit and leaves its lane result untouched. Register files and instruction decode sit outside this block.

Top module: `wave_cmpsel`

## Requirements
- R1: While reset is held and after it is released: `cond_o` is all zeros, `exec_o` is all ones, `res_o` is zero, and `res_valid_o`, `done_o` and `busy_o` are low.
- R2: Pass timing.
  - A start pulse is accepted while `busy_o` is low. The operands present in that cycle form beat 0, and the next three cycles carry beats 1, 2 and 3.
  - One cycle after each beat, `res_valid_o` is high and `res_beat_o` holds that beat's index.
  - `done_o` pulses one cycle after beat 3, and a new start is accepted in that same cycle.
  - A start pulse during beats 1 to 3 is ignored.
- R3: In a compare pass, the outcome of lane j in beat k lands in bit 16k+j of `cond_o`.
- R4: `cond_o` and `exec_o` change only in the cycle in which `done_o` is high. During a pass they keep their previous values.
- R5: The execute mask is sampled with the start pulse. An element whose mask bit is 0 yields a 0 condition bit, and its result lane keeps its previous value.
- R6: When opcode bit 4 is 1 in a compare pass, `exec_o` receives the same 64 bits as `cond_o`. Otherwise `exec_o` keeps its value.
- R7: Opcode bit 5 = 0 selects a compare. Bits 3:0 select the predicate of A against B:
  - 0: false
  - 1: less
  - 2: equal
  - 3: less-or-equal
  - 4: greater
  - 5: less-or-greater
  - 6: greater-or-equal
  - 7: ordered
  - 8: unordered
  - 9: not greater-or-equal
  - 10: not less-or-greater
  - 11: not greater
  - 12: not less-or-equal
  - 13: not equal
  - 14: not less
  - 15: true
- R8: If either compare operand is a NaN (exponent all ones and mantissa not zero), every ordered predicate (codes 1 to 7) is false and every unordered one (codes 8 to 14) is true. -0.0 and +0.0 compare equal.
- R9: Opcode bit 5 = 1 selects a three-way select on bits 1:0: 0 gives the minimum, 1 the maximum, and 2 or 3 the median.
- R10: Minimum and maximum skip NaN operands, and all-NaN inputs give 32'h7FC00000. When the median sees a NaN, it drops the first NaN in the order A, B, C and returns the minimum of the other two, with the same NaN rule.
- R11: In select ordering, -0.0 is below +0.0.
- R12: A compare pass leaves `res_o` unchanged. A select pass leaves `cond_o` and `exec_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a pass; the operands in the same cycle are beat 0 |
| op_i | input | 6 | Opcode: bit 5 selects select or compare, bit 4 is the execute-mask copy flag, bits 3:0 hold the predicate or select kind |
| src_a_i | input | 512 | Operand A, 16 lanes of 32 bits, lane j at bits 32j+31:32j |
| src_b_i | input | 512 | Operand B, same layout |
| src_c_i | input | 512 | Operand C, same layout |
| exec_i | input | 64 | Execute mask for the pass, sampled with the start pulse |
| res_o | output | 512 | Select results per lane |
| res_valid_o | output | 1 | High one cycle after each beat |
| res_beat_o | output | 2 | Index of the beat just completed |
| cond_o | output | 64 | Condition mask from the last compare pass |
| exec_o | output | 64 | Execute mask as updated by compares |
| done_o | output | 1 | Pulse one cycle after beat 3 |
| busy_o | output | 1 | High while beats 1 to 3 of a pass are in progress |

## Verification
The end of one pass and the start of the next can share a cycle. In that cycle `done_o` publishes the condition and execute masks, while beat 0 of the next pass already writes lane results and samples a fresh execute mask. The bench provokes this by issuing a new start in the cycle right after the previous pass's last beat. It then checks three things: the published masks belong wholly to the older pass, the next pass's beat 0 results sit on `res_o`, and the older pass's copied `exec_o` value plays no part in the newer pass. A second overlap is a start pulse arriving mid-pass; the bench checks that it changes neither the running pass nor the number of `done_o` pulses.

// File: rtl/wave_cmpsel_pkg.sv
package wave_cmpsel_pkg;

  localparam int FW = 32;
  localparam logic [FW-1:0] CANON_NAN = 32'h7FC0_0000;

  typedef struct packed {
    logic       is_sel;   // 1: three-way select, 0: compare
    logic       wr_exec;  // compare result also goes to execute mask
    logic [3:0] code;     // predicate or select kind
  } op_t;

  function automatic logic is_nan(input logic [FW-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  // Maps sign-magnitude floats onto an unsigned total order (-0 below +0).
  function automatic logic [FW-1:0] ord_key(input logic [FW-1:0] x);
    return x[31] ? ~x : {1'b1, x[30:0]};
  endfunction

  function automatic logic below(input logic [FW-1:0] x, input logic [FW-1:0] y);
    return ord_key(x) < ord_key(y);
  endfunction

endpackage

// File: rtl/wave_cmpsel_sync.sv
module wave_cmpsel_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/wave_cmpsel_seq.sv
module wave_cmpsel_seq #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              start_acc_o,
  output logic              active_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o,
  output logic              busy_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              busy_q, busy_n;
  logic [BEAT_W-1:0] beat_q, beat_n;

  // R2: a start is taken only between passes
  always_comb begin
    start_acc_o = start_i && !busy_q;
    active_o    = start_acc_o || busy_q;
    beat_o      = start_acc_o ? '0 : beat_q;
    last_o      = active_o && (beat_o == LAST_BEAT);
    busy_n      = busy_q;
    beat_n      = beat_q;
    if (active_o) begin
      busy_n = !last_o;
      beat_n = last_o ? '0 : beat_o + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (active_o) begin
      busy_q <= busy_n;
      beat_q <= beat_n;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/wave_cmpsel_cmp.sv
module wave_cmpsel_cmp
  import wave_cmpsel_pkg::*;
(
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  input  logic [3:0]    code_i,
  output logic          hit_o
);
  logic [FW-1:0] a_z, b_z;
  logic          unord, eq, lt, gt, base;
  logic [2:0]    rel_mask;

  always_comb begin
    // R8: signed zeros fold together for predicates
    a_z      = (a_i[30:0] == 31'd0) ? '0 : a_i;
    b_z      = (b_i[30:0] == 31'd0) ? '0 : b_i;
    unord    = is_nan(a_i) || is_nan(b_i);
    eq       = (a_z == b_z);
    lt       = below(a_z, b_z);
    gt       = !eq && !lt;
    // R7: upper half of the code space negates the mirrored lower code
    rel_mask = code_i[3] ? ~code_i[2:0] : code_i[2:0];
    base     = !unord && |(rel_mask & {gt, eq, lt});
    hit_o    = code_i[3] ^ base;
  end
endmodule

// File: rtl/wave_cmpsel_sel.sv
module wave_cmpsel_sel
  import wave_cmpsel_pkg::*;
(
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  input  logic [FW-1:0] c_i,
  input  logic [1:0]    kind_i,
  output logic [FW-1:0] y_o
);
  // R10: NaN operands are skipped; two NaNs leave a NaN
  function automatic logic [FW-1:0] lo2(input logic [FW-1:0] x, input logic [FW-1:0] y);
    if (is_nan(x)) return y;
    if (is_nan(y)) return x;
    return below(y, x) ? y : x;
  endfunction

  function automatic logic [FW-1:0] hi2(input logic [FW-1:0] x, input logic [FW-1:0] y);
    if (is_nan(x)) return y;
    if (is_nan(y)) return x;
    return below(x, y) ? y : x;
  endfunction

  function automatic logic [FW-1:0] canon(input logic [FW-1:0] x);
    return is_nan(x) ? CANON_NAN : x;
  endfunction

  logic [FW-1:0] mn, mx, md;

  always_comb begin
    mn = canon(lo2(lo2(a_i, b_i), c_i));
    mx = canon(hi2(hi2(a_i, b_i), c_i));
    if (is_nan(a_i))      md = lo2(b_i, c_i);
    else if (is_nan(b_i)) md = lo2(a_i, c_i);
    else if (is_nan(c_i)) md = lo2(a_i, b_i);
    else                  md = hi2(lo2(a_i, b_i), lo2(hi2(a_i, b_i), c_i)); // R11
    md = canon(md);
    unique case (kind_i)     // R9
      2'd0:    y_o = mn;
      2'd1:    y_o = mx;
      default: y_o = md;
    endcase
  end
endmodule

// File: rtl/wave_cmpsel.sv
module wave_cmpsel
  import wave_cmpsel_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BEATS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [5:0]          op_i,
  input  logic [LANES*32-1:0] src_a_i,
  input  logic [LANES*32-1:0] src_b_i,
  input  logic [LANES*32-1:0] src_c_i,
  input  logic [LANES*BEATS-1:0] exec_i,
  output logic [LANES*32-1:0] res_o,
  output logic                res_valid_o,
  output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] res_beat_o,
  output logic [LANES*BEATS-1:0] cond_o,
  output logic [LANES*BEATS-1:0] exec_o,
  output logic                done_o,
  output logic                busy_o
);
  localparam int WAVE   = LANES * BEATS;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              rst_n_s;
  logic              start_acc, active, last;
  logic [BEAT_W-1:0] cur_beat;

  op_t               op_q, op_eff;
  logic [WAVE-1:0]   mask_q, mask_eff;
  logic [LANES-1:0]  lane_mask, hits;
  logic [LANES*FW-1:0] sel_vals;

  logic [WAVE-1:0]     shadow_q, shadow_n, cond_q, cond_n, exec_q, exec_n;
  logic [LANES*FW-1:0] res_q, res_n;
  logic                valid_q, done_q;
  logic [BEAT_W-1:0]   rbeat_q;

  wave_cmpsel_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s));

  wave_cmpsel_seq #(.BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i),
    .start_acc_o(start_acc), .active_o(active), .beat_o(cur_beat),
    .last_o(last), .busy_o(busy_o)
  );

  // R5: opcode and mask are taken from the ports in the start cycle
  always_comb begin
    op_eff    = start_acc ? op_t'(op_i) : op_q;
    mask_eff  = start_acc ? exec_i : mask_q;
    lane_mask = mask_eff[int'(cur_beat)*LANES +: LANES];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    wave_cmpsel_cmp u_cmp (
      .a_i(src_a_i[j*FW +: FW]), .b_i(src_b_i[j*FW +: FW]),
      .code_i(op_eff.code), .hit_o(hits[j])
    );
    wave_cmpsel_sel u_sel (
      .a_i(src_a_i[j*FW +: FW]), .b_i(src_b_i[j*FW +: FW]),
      .c_i(src_c_i[j*FW +: FW]), .kind_i(op_eff.code[1:0]),
      .y_o(sel_vals[j*FW +: FW])
    );
  end

  always_comb begin
    shadow_n = shadow_q;
    cond_n   = cond_q;
    exec_n   = exec_q;
    res_n    = res_q;
    if (active) begin
      if (!op_eff.is_sel) begin
        // R3: beat k fills bits 16k..16k+15; R5: masked bits read 0
        shadow_n[int'(cur_beat)*LANES +: LANES] = hits & lane_mask;
      end else begin
        for (int j = 0; j < LANES; j++) begin
          if (lane_mask[j]) res_n[j*FW +: FW] = sel_vals[j*FW +: FW];
        end
      end
      // R4, R6, R12: publish only at the end of a compare pass
      if (last && !op_eff.is_sel) begin
        cond_n = shadow_n;
        if (op_eff.wr_exec) exec_n = shadow_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q   <= '0;
      mask_q <= '0;
    end else if (start_acc) begin
      op_q   <= op_eff;
      mask_q <= exec_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      shadow_q <= '0;
      cond_q   <= '0;
      exec_q   <= '1;
      res_q    <= '0;
    end else if (active) begin
      shadow_q <= shadow_n;
      cond_q   <= cond_n;
      exec_q   <= exec_n;
      res_q    <= res_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      rbeat_q <= '0;
    end else begin
      valid_q <= active;
      done_q  <= last;
      if (active) rbeat_q <= cur_beat;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = valid_q;
  assign res_beat_o  = rbeat_q;
  assign cond_o      = cond_q;
  assign exec_o      = exec_q;
  assign done_o      = done_q;
endmodule

// File: rtl/wave_cmpsel_chk.sv
module wave_cmpsel_chk #(
  parameter int LANES = 16,
  parameter int BEATS = 4,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   res_valid_o,
  input logic [BEAT_W-1:0]      res_beat_o,
  input logic [LANES*BEATS-1:0] cond_o,
  input logic [LANES*BEATS-1:0] exec_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  assert_cond_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(cond_o));

  assert_exec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(exec_o));

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_last_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_beat_o == LAST_BEAT) |-> done_o);

  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_beat_o != LAST_BEAT) |=>
      (res_valid_o && res_beat_o == BEAT_W'($past(res_beat_o) + BEAT_W'(1))));

  assert_pass_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (res_valid_o && res_beat_o == '0));
endmodule

bind wave_cmpsel wave_cmpsel_chk #(.LANES(LANES), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .res_valid_o(res_valid_o), .res_beat_o(res_beat_o),
  .cond_o(cond_o), .exec_o(exec_o)
);

// File: tb/tb_wave_cmpsel.sv
`timescale 1ns/1ps
module tb_wave_cmpsel;
  localparam int L = 16;
  localparam int B = 4;
  localparam int N = L * B;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000, P3 = 32'h4040_0000;
  localparam logic [31:0] M1 = 32'hBF80_0000, M2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, QN2 = 32'hFFC0_0001, SN = 32'h7F80_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] op_i = '0;
  logic [L*32-1:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
  logic [N-1:0] exec_i = '0;
  logic [L*32-1:0] res_o;
  logic res_valid_o, done_o, busy_o;
  logic [1:0] res_beat_o;
  logic [N-1:0] cond_o, exec_o;

  always #4 clk = ~clk;

  wave_cmpsel dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i), .exec_i(exec_i),
    .res_o(res_o), .res_valid_o(res_valid_o), .res_beat_o(res_beat_o),
    .cond_o(cond_o), .exec_o(exec_o), .done_o(done_o), .busy_o(busy_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] ea [N], eb [N], ec [N];
  logic [31:0] emin [N], emax [N], emed [N];
  int          erel [N];   // 0 less, 1 equal, 2 greater, 3 unordered
  logic [31:0] m_res [L];
  logic [N-1:0] m_cond, m_exec;

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit pred(input int code, input int rel);
    bit lt = (rel == 0), eq = (rel == 1), gt = (rel == 2), un = (rel == 3);
    case (code)
      0: return 0;          1: return lt;          2: return eq;
      3: return lt | eq;    4: return gt;          5: return lt | gt;
      6: return gt | eq;    7: return !un;         8: return un;
      9: return un | lt;    10: return un | eq;    11: return !gt;
      12: return un | gt;   13: return !eq;        14: return un | gt | eq;
      default: return 1;
    endcase
  endfunction

  task automatic fill_cmp(input int seed);
    for (int i = 0; i < N; i++) begin
      ec[i] = PZ;
      case ((i * 3 + seed) % 7)
        0: begin ea[i] = P1;   eb[i] = P2; erel[i] = 0; end
        1: begin ea[i] = P2;   eb[i] = P1; erel[i] = 2; end
        2: begin ea[i] = P1;   eb[i] = P1; erel[i] = 1; end
        3: begin ea[i] = QN;   eb[i] = P1; erel[i] = 3; end
        4: begin ea[i] = NZ;   eb[i] = PZ; erel[i] = 1; end
        5: begin ea[i] = M1;   eb[i] = QN2; erel[i] = 3; end
        default: begin ea[i] = NINF; eb[i] = M1; erel[i] = 0; end
      endcase
    end
  endtask

  task automatic fill_sel(input int seed);
    for (int i = 0; i < N; i++) begin
      erel[i] = 0;
      case ((i * 5 + seed) % 8)
        0: begin ea[i]=P1;   eb[i]=P2;   ec[i]=M1;  emin[i]=M1;   emax[i]=P2;   emed[i]=P1; end
        1: begin ea[i]=QN;   eb[i]=P2;   ec[i]=P1;  emin[i]=P1;   emax[i]=P2;   emed[i]=P1; end
        2: begin ea[i]=SN;   eb[i]=QN2;  ec[i]=QN;  emin[i]=QN;   emax[i]=QN;   emed[i]=QN; end
        3: begin ea[i]=NZ;   eb[i]=PZ;   ec[i]=PZ;  emin[i]=NZ;   emax[i]=PZ;   emed[i]=PZ; end
        4: begin ea[i]=P2;   eb[i]=QN;   ec[i]=SN;  emin[i]=P2;   emax[i]=P2;   emed[i]=P2; end
        5: begin ea[i]=PZ;   eb[i]=NZ;   ec[i]=P1;  emin[i]=NZ;   emax[i]=P1;   emed[i]=PZ; end
        6: begin ea[i]=PINF; eb[i]=NINF; ec[i]=P1;  emin[i]=NINF; emax[i]=PINF; emed[i]=P1; end
        default: begin ea[i]=P3; eb[i]=P3; ec[i]=M2; emin[i]=M2; emax[i]=P3; emed[i]=P3; end
      endcase
    end
  endtask

  task automatic drive_beat(input int k);
    for (int j = 0; j < L; j++) begin
      src_a_i[j*32 +: 32] = ea[k*L + j];
      src_b_i[j*32 +: 32] = eb[k*L + j];
      src_c_i[j*32 +: 32] = ec[k*L + j];
    end
  endtask

  function automatic logic [511:0] pack_res();
    logic [511:0] v = '0;
    for (int j = 0; j < L; j++) v[j*32 +: 32] = m_res[j];
    return v;
  endfunction

  // Called at a falling edge; drives a whole pass and checks every beat.
  task automatic run_pass(input logic [5:0] op, input logic [N-1:0] mask,
                          input string tag, input bit mid_start, input bit idle_after);
    logic [N-1:0] cond_before = cond_o;
    logic [N-1:0] exec_before = exec_o;
    start_i = 1'b1; op_i = op; exec_i = mask; drive_beat(0);
    for (int k = 0; k < B; k++) begin
      @(negedge clk);
      chk(res_valid_o && res_beat_o == 2'(k), "R2 beat flag", {res_valid_o, res_beat_o}, {1'b1, 2'(k)});
      if (op[5]) begin
        for (int j = 0; j < L; j++) begin
          if (mask[k*L + j]) begin
            case (op[1:0])
              2'd0: m_res[j] = emin[k*L + j];
              2'd1: m_res[j] = emax[k*L + j];
              default: m_res[j] = emed[k*L + j];
            endcase
          end
        end
      end
      chk(res_o == pack_res(), {tag, " lanes (R5 R12)"}, res_o, pack_res());
      if (k < B - 1) begin
        chk(cond_o == cond_before && exec_o == exec_before && !done_o,
            "R4 masks held mid-pass", {cond_o, exec_o}, {cond_before, exec_before});
        start_i = (mid_start && k == 0) ? 1'b1 : 1'b0;
        if (mid_start && k == 0) op_i = 6'h20;
        exec_i = ~mask;
        drive_beat(k + 1);
      end
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R2 done pulse", done_o, 1);
    if (!op[5]) begin
      for (int i = 0; i < N; i++) m_cond[i] = mask[i] & pred(int'(op[3:0]), erel[i]);
      if (op[4]) m_exec = m_cond;
    end
    chk(cond_o == m_cond, {tag, " cond (R3 R7 R8 R12)"}, cond_o, m_cond);
    chk(exec_o == m_exec, "R6 exec mask", exec_o, m_exec);
    if (idle_after) begin
      @(negedge clk);
      chk(!done_o && !res_valid_o && !busy_o, "R2 idle after pass",
          {done_o, res_valid_o, busy_o}, 3'b000);
    end
  endtask

  task automatic t_reset();
    chk(cond_o == '0 && exec_o == '1 && res_o == '0 && !res_valid_o && !done_o && !busy_o,
        "R1 reset state", {cond_o, exec_o}, {64'h0, {64{1'b1}}});
  endtask

  task automatic t_predicates();
    for (int c = 0; c < 16; c++) begin
      fill_cmp(c);
      run_pass({2'b00, 4'(c)}, '1, "R7 predicate", 1'b0, 1'b1);
    end
  endtask

  task automatic t_mask_cmp();
    fill_cmp(2);
    run_pass(6'h13, 64'h0F0F_3C3C_A5A5_FF00, "R5 masked compare", 1'b0, 1'b1);
    fill_cmp(4);
    run_pass(6'h0F, 64'h0000_FFFF_0000_FFFF, "R6 no exec copy", 1'b0, 1'b1);
  endtask

  task automatic t_select();
    fill_sel(0); run_pass(6'h20, '1, "R10 R11 min3", 1'b0, 1'b1);
    fill_sel(3); run_pass(6'h21, '1, "R10 R11 max3", 1'b0, 1'b1);
    fill_sel(5); run_pass(6'h22, '1, "R10 R11 med3", 1'b0, 1'b1);
    fill_sel(1); run_pass(6'h23, '1, "R9 med3 alt code", 1'b0, 1'b1);
    fill_sel(6); run_pass(6'h30, 64'hF0F0_1234_8001_00FF, "R5 masked select", 1'b0, 1'b1);
  endtask

  task automatic t_mid_start();
    fill_cmp(5);
    run_pass(6'h16, '1, "R2 start ignored", 1'b1, 1'b1);
  endtask

  task automatic t_back_to_back();
    fill_cmp(1);
    run_pass(6'h1B, 64'hFFFF_0000_FFFF_00FF, "R2 back-to-back A", 1'b0, 1'b0);
    fill_sel(2);
    run_pass(6'h22, 64'hAAAA_5555_FFFF_0F0F, "R2 back-to-back B", 1'b0, 1'b0);
    fill_cmp(6);
    run_pass(6'h05, '1, "R2 back-to-back C", 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int j = 0; j < L; j++) m_res[j] = '0;
    m_cond = '0;
    m_exec = '1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_predicates();
    t_mask_cmp();
    t_select();
    t_mid_start();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule